// File: doc/BRIEF.md
# Watermark-Interrupt Serial Port

This block is a serial port peripheral behind a word-wide register bus. Software queues characters into an 8-entry transmit queue, and a shifter sends them as 8N1 or 8N2 frames on `tx`. A receiver samples `rx` and stores complete characters in an 8-entry receive queue. One divisor register sets the bit period for both directions. The status flags share the data registers. Reading the receive data word removes the character it shows, so that read has a side effect.

Interrupts are level conditions and do not latch events. The transmit condition is true while the transmit queue holds fewer characters than a programmed level. The receive condition is true while the receive queue holds more characters than its level. A receive level of zero therefore requests service as soon as one character is waiting. Each condition is masked by its own enable bit onto a single `irq` line. The usual setup is a receive level of 0 for a byte-at-a-time console, or a transmit level of 1 to be told when the queue is nearly drained.

Top module: `wm_uart`

## Requirements
- R1: After reset, every register reads zero except the receive data word, which reads 0x8000_0000. `irq` is low and `tx` is high. Word offsets 0x00 to 0x18 are decoded by `bus_addr[4:2]`, and offset 0x1C reads zero.
- R2: One bit lasts divisor+1 clock cycles. The divisor is the word at 0x18. While the divisor is zero, no new transmit frame starts and no reception begins.
- R3: A transmit frame is one low start bit, then 8 data bits sent LSB first, then one high stop bit, or two when bit 1 of transmit control (0x08) is set. Queued characters follow each other with no gap, so frames repeat every (10 or 11)×(divisor+1) cycles.
- R4: A write to 0x00 queues `bus_wdata[7:0]`. Reading 0x00 returns bit 31 set exactly when 8 characters are queued. A write made while the queue is full is discarded.
- R5: Reading 0x04 returns bit 31 set and bits 7:0 zero when the receive queue is empty. Otherwise it returns the oldest character in bits 7:0 and removes it. A read of an empty queue changes nothing.
- R6: With `tx` looped to `rx` and a divisor of 3 or more, received characters are queued in arrival order. A character that completes while the receive queue is full is lost, and the 8 queued characters are kept.
- R7: Bit 0 of the pending word (0x14, read-only) is 1 exactly when the transmit occupancy is less than transmit control bits 18:16.
- R8: Bit 1 of the pending word is 1 exactly when the receive occupancy is greater than receive control (0x0C) bits 18:16.
- R9: `irq` is the OR of pending bit 0 AND enable bit 0, with pending bit 1 AND enable bit 1. The enable word is at 0x10. The pending word itself is not masked.
- R10: Clearing bit 0 of transmit control lets the current frame finish, then holds `tx` high and keeps the queued characters. Setting it again resumes with the next character. Bit 0 of receive control gates only the start of a reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, valid in the access cycle |
| irq | output | 1 | Masked watermark interrupt |
| tx | output | 1 | Serial output, idle high |
| rx | input | 1 | Serial input, asynchronous |

## Verification
Two events can fall in the same cycle: a bus read that removes the head of the receive queue, and a stop-bit sample that appends a character. To provoke this, eight back-to-back frames are sent over the loopback while the bench reads the receive data word on every cycle, so some reads land on the append cycle. The result is judged by the collected stream: all eight characters must arrive once each, in order, and the queue must read empty afterwards. The transmit side sees the same kind of overlap. There, a load into the shifter coincides with bus writes, and this is covered by the frame-period and data checks.

// File: rtl/wm_uart.sv
module wm_uart #(
  parameter int DEPTH = 8,
  parameter int DIV_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        tx,
  input  logic        rx
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [2:0] widx;
  logic       wr, rd;
  assign widx = bus_addr[4:2];
  assign wr   = bus_en & bus_we;
  assign rd   = bus_en & ~bus_we;

  logic unused_bits;
  assign unused_bits = ^{bus_wdata, bus_addr[1:0]};

  logic             tx_en_q, tx_two_q, rx_en_q;
  logic [2:0]       tx_wm_q, rx_wm_q;
  logic [1:0]       ie_q;
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en_q  <= 1'b0;
      tx_two_q <= 1'b0;
      tx_wm_q  <= '0;
      rx_en_q  <= 1'b0;
      rx_wm_q  <= '0;
      ie_q     <= '0;
      div_q    <= '0;
    end else if (wr) begin
      case (widx)
        3'd2: begin
          tx_en_q  <= bus_wdata[0];
          tx_two_q <= bus_wdata[1];
          tx_wm_q  <= bus_wdata[18:16];
        end
        3'd3: begin
          rx_en_q <= bus_wdata[0];
          rx_wm_q <= bus_wdata[18:16];
        end
        3'd4: ie_q  <= bus_wdata[1:0];
        3'd6: div_q <= bus_wdata[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  // transmit queue
  logic [7:0]    tx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt;
  logic          tx_full, tx_push, tx_load;

  assign tx_full = (tx_cnt == FULL);
  assign tx_push = wr && widx == 3'd0 && !tx_full;

  always_ff @(posedge clk)
    if (tx_push) tx_mem[tx_wp] <= bus_wdata[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_load) tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + {{AW{1'b0}}, tx_push} - {{AW{1'b0}}, tx_load};
    end
  end

  // transmit shifter
  logic             tx_busy, tx_two_f;
  logic [3:0]       tx_idx;
  logic [DIV_W-1:0] tx_tmr;
  logic [10:0]      tx_frm;
  logic             tx_tick, tx_fin, tx_go;

  assign tx_tick = tx_busy && (tx_tmr >= div_q);
  assign tx_fin  = tx_tick && (tx_idx == (tx_two_f ? 4'd10 : 4'd9));
  assign tx_go   = tx_en_q && (tx_cnt != '0) && (div_q != '0);
  assign tx_load = tx_go && (!tx_busy || tx_fin);
  assign tx      = !tx_busy | tx_frm[tx_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy  <= 1'b0;
      tx_two_f <= 1'b0;
      tx_idx   <= '0;
      tx_tmr   <= '0;
      tx_frm   <= '1;
    end else if (tx_load) begin
      tx_busy  <= 1'b1;
      tx_two_f <= tx_two_q;
      tx_idx   <= '0;
      tx_tmr   <= '0;
      tx_frm   <= {2'b11, tx_mem[tx_rp], 1'b0};
    end else if (tx_fin) begin
      tx_busy <= 1'b0;
    end else if (tx_tick) begin
      tx_idx <= tx_idx + 1'b1;
      tx_tmr <= '0;
    end else if (tx_busy) begin
      tx_tmr <= tx_tmr + 1'b1;
    end
  end

  // receive sampling
  logic             s1, s2, s3;
  logic             rx_busy;
  logic [3:0]       rx_idx;
  logic [DIV_W-1:0] rx_tmr, rx_first;
  logic [DIV_W:0]   half;
  logic [7:0]       rx_sr;
  logic             rx_start, rx_samp, rx_push, rx_pop, rx_full, rx_empty;
  logic [CW-1:0]    rx_cnt;

  assign half     = ({1'b0, div_q} + 1'b1) >> 1;
  assign rx_first = (half >= (DIV_W+1)'(2)) ? DIV_W'(half - (DIV_W+1)'(2)) : '0;
  assign rx_start = !rx_busy && rx_en_q && (div_q != '0) && !s2 && s3;
  assign rx_samp  = rx_busy && (rx_tmr == '0);
  assign rx_push  = rx_samp && rx_idx == 4'd9 && s2 && !rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= rx;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_busy <= 1'b0;
      rx_idx  <= '0;
      rx_tmr  <= '0;
      rx_sr   <= '0;
    end else if (rx_start) begin
      rx_busy <= 1'b1;
      rx_idx  <= '0;
      rx_tmr  <= rx_first;
    end else if (rx_samp) begin
      rx_tmr <= div_q;
      rx_idx <= rx_idx + 1'b1;
      if (rx_idx == 4'd0 && s2) rx_busy <= 1'b0;
      else if (rx_idx == 4'd9) rx_busy <= 1'b0;
      else if (rx_idx != 4'd0) rx_sr <= {s2, rx_sr[7:1]};
    end else if (rx_busy) begin
      rx_tmr <= rx_tmr - 1'b1;
    end
  end

  // receive queue
  logic [7:0]    rx_mem [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp;

  assign rx_full  = (rx_cnt == FULL);
  assign rx_empty = (rx_cnt == '0);
  assign rx_pop   = rd && widx == 3'd1 && !rx_empty;

  always_ff @(posedge clk)
    if (rx_push) rx_mem[rx_wp] <= rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp  <= '0;
      rx_rp  <= '0;
      rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + {{AW{1'b0}}, rx_push} - {{AW{1'b0}}, rx_pop};
    end
  end

  // interrupts and read mux
  logic [1:0] pend;
  assign pend = {rx_cnt > CW'(rx_wm_q), tx_cnt < CW'(tx_wm_q)};
  assign irq  = |(pend & ie_q);

  always_comb begin
    bus_rdata = '0;
    case (widx)
      3'd0: bus_rdata[31] = tx_full;
      3'd1: begin
        bus_rdata[31]  = rx_empty;
        bus_rdata[7:0] = rx_empty ? 8'h00 : rx_mem[rx_rp];
      end
      3'd2: begin
        bus_rdata[0]     = tx_en_q;
        bus_rdata[1]     = tx_two_q;
        bus_rdata[18:16] = tx_wm_q;
      end
      3'd3: begin
        bus_rdata[0]     = rx_en_q;
        bus_rdata[18:16] = rx_wm_q;
      end
      3'd4: bus_rdata[1:0] = ie_q;
      3'd5: bus_rdata[1:0] = pend;
      3'd6: bus_rdata[DIV_W-1:0] = div_q;
      default: ;
    endcase
  end

  // R4
  tx_full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && widx == 3'd0 && tx_cnt == FULL && !tx_load) |=> tx_cnt == FULL);

  // R4
  tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= FULL);

  // R5
  rx_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop == 1'b0 && rd && widx == 3'd1 && rx_cnt == '0 && !rx_push) |=> rx_cnt == '0);

  // R6
  rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= FULL);

  // R2
  div_zero_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0 && !tx_busy) |=> !tx_busy);

  // R2
  div_zero_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0 && !rx_busy) |=> !rx_busy);

endmodule

// File: tb/wm_uart_bench.sv
module wm_uart_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, txd;
  int          checks = 0, errors = 0;
  bit          done = 0;

  wm_uart u_wm_uart (
    .clk(clk), .rst_n(rst_n), .bus_en(en), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq), .tx(txd), .rx(txd)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] v);
    @(negedge clk); en = 1'b1; we = 1'b1; addr = a; wdata = v;
    @(posedge clk); #1 en = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); en = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(posedge clk); #1 en = 1'b0;
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic find_fall();
    int lim;
    lim = 0;
    @(negedge clk);
    while (txd !== 1'b0 && lim < 3000) begin @(negedge clk); lim++; end
  endtask

  task automatic frame_case(input int ns, input int dv, input int di);
    logic [7:0]  b [3];
    logic [31:0] d;
    int P, pos, bad, tgt;
    logic e;
    P = dv + 1;
    for (int i = 0; i < 3; i++) b[i] = 8'(8'h35 * (i + 1) + ns * 64 + di * 7);
    wr(5'h18, 32'(dv));
    wr(5'h08, {30'd0, ns[0], 1'b0});
    for (int i = 0; i < 3; i++) wr(5'h00, {24'd0, b[i]});
    wr(5'h08, {30'd0, ns[0], 1'b1});
    find_fall();
    pos = 0; bad = 0;
    for (int k = 0; k < 10 + ns; k++) begin
      tgt = k * P + P / 2;
      repeat (tgt - pos) @(negedge clk);
      pos = tgt;
      e = (k == 0) ? 1'b0 : (k <= 8) ? b[0][k-1] : 1'b1;
      if (txd !== e) bad++;
    end
    // R3 frame shape
    chk(bad == 0, "R3 frame bits", 32'(bad), 0);
    while (txd !== 1'b0 && pos < 5000) begin @(negedge clk); pos++; end
    // R2 R3 frame period
    chk(pos == (10 + ns) * P, "R3 period", 32'(pos), 32'((10 + ns) * P));
    ticks(3 * 11 * P + 40);
    for (int i = 0; i < 3; i++) begin
      rd(5'h04, d);
      chk(d == {24'd0, b[i]}, "R6 loopback data", d, {24'd0, b[i]});
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] ex;
    int bad, got;
    logic [7:0] seen [8];
    ticks(3);
    rst_n = 1'b1;
    ticks(2);

    // R1 reset values
    chk(irq === 1'b0 && txd === 1'b1, "R1 irq/tx", {30'd0, irq, txd}, 32'h1);
    for (int a = 0; a < 8; a++) begin
      rd(5'(a * 4), d);
      ex = (a == 1) ? 32'h8000_0000 : 32'h0;
      chk(d == ex, "R1 reset read", d, ex);
    end

    // R2 divisor zero holds both directions idle
    wr(5'h0C, 32'h1);
    wr(5'h08, 32'h1);
    wr(5'h00, 32'h5A);
    bad = 0;
    for (int i = 0; i < 80; i++) begin @(negedge clk); if (txd !== 1'b1) bad++; end
    chk(bad == 0, "R2 div zero idle", 32'(bad), 0);
    wr(5'h18, 32'd5);
    ticks(12 * 6 + 30);
    rd(5'h04, d);
    chk(d == 32'h5A, "R2 start after divisor", d, 32'h5A);

    // R3 stop-bit and divisor sweep
    for (int ns = 0; ns < 2; ns++)
      for (int di = 0; di < 3; di++)
        frame_case(ns, (di == 0) ? 3 : (di == 1) ? 5 : 8, di);

    // R4 R7 R9 transmit fill with watermark sweep
    wr(5'h18, 32'd3);
    wr(5'h08, 32'h0);
    wr(5'h10, 32'h1);
    for (int c = 0; c <= 8; c++) begin
      for (int wm = 0; wm < 8; wm++) begin
        wr(5'h08, 32'(wm) << 16);
        rd(5'h14, d);
        ex = {31'd0, c < wm};
        chk(d == ex, "R7 tx pending", d, ex);
        chk(irq === (c < wm), "R9 tx irq", {31'd0, irq}, {31'd0, c < wm});
      end
      rd(5'h00, d);
      ex = (c == 8) ? 32'h8000_0000 : 32'h0;
      chk(d == ex, "R4 full flag", d, ex);
      if (c < 8) wr(5'h00, 32'(8'h10 + c));
    end
    wr(5'h00, 32'hEE);
    rd(5'h00, d);
    chk(d == 32'h8000_0000, "R4 still full", d, 32'h8000_0000);
    wr(5'h08, 32'h0007_0001);
    ticks(8 * 40 + 80);

    // R8 R9 receive drain with watermark sweep
    wr(5'h10, 32'h2);
    for (int c = 8; c >= 0; c--) begin
      for (int wm = 0; wm < 8; wm++) begin
        wr(5'h0C, 32'h1 | (32'(wm) << 16));
        rd(5'h14, d);
        ex = {30'd0, c > wm, 1'b1};
        chk(d == ex, "R8 rx pending", d, ex);
        chk(irq === (c > wm), "R9 rx irq", {31'd0, irq}, {31'd0, c > wm});
      end
      rd(5'h04, d);
      ex = (c == 0) ? 32'h8000_0000 : 32'(8'h10 + 8 - c);
      chk(d == ex, "R4 R5 drain order", d, ex);
    end
    wr(5'h10, 32'h0);
    wr(5'h0C, 32'h1);

    // R6 receive overflow drops
    wr(5'h08, 32'h1);
    for (int i = 0; i < 8; i++) wr(5'h00, 32'(8'h40 + i));
    ticks(8 * 40 + 60);
    wr(5'h00, 32'hBB);
    ticks(80);
    for (int i = 0; i < 8; i++) begin
      rd(5'h04, d);
      chk(d == 32'(8'h40 + i), "R6 kept on overflow", d, 32'(8'h40 + i));
    end
    rd(5'h04, d);
    chk(d == 32'h8000_0000, "R5 R6 dropped char", d, 32'h8000_0000);
    rd(5'h04, d);
    chk(d == 32'h8000_0000, "R5 empty read stable", d, 32'h8000_0000);

    // R10 disable mid-frame
    wr(5'h18, 32'd5);
    wr(5'h08, 32'h0);
    wr(5'h00, 32'h61);
    wr(5'h00, 32'h62);
    wr(5'h08, 32'h1);
    find_fall();
    ticks(18);
    wr(5'h08, 32'h0);
    ticks(12 * 6);
    bad = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (txd !== 1'b1) bad++; end
    chk(bad == 0, "R10 idle after disable", 32'(bad), 0);
    rd(5'h04, d);
    chk(d == 32'h61, "R10 current frame done", d, 32'h61);
    rd(5'h04, d);
    chk(d == 32'h8000_0000, "R10 no next frame", d, 32'h8000_0000);
    wr(5'h08, 32'h1);
    ticks(12 * 6 + 30);
    rd(5'h04, d);
    chk(d == 32'h62, "R10 resume", d, 32'h62);

    // R5 R6 reads racing receive pushes
    wr(5'h18, 32'd3);
    for (int i = 0; i < 8; i++) wr(5'h00, 32'(8'hC0 + i * 3));
    got = 0;
    for (int t = 0; t < 1200 && got < 8; t++) begin
      rd(5'h04, d);
      if (!d[31]) begin seen[got] = d[7:0]; got++; end
    end
    chk(got == 8, "R6 stream count", 32'(got), 8);
    for (int i = 0; i < 8; i++)
      chk(i < got && seen[i] == 8'(8'hC0 + i * 3), "R5 stream order",
          {24'd0, seen[i]}, 32'(8'hC0 + i * 3));
    ticks(100);
    rd(5'h04, d);
    chk(d == 32'h8000_0000, "R5 stream empty", d, 32'h8000_0000);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule